// File: doc/BRIEF.md
# Receive Address Filter and Packet Ring Writer

This block sits on the receive side of an Ethernet controller. Frames arrive as a byte stream with first-byte and last-byte markers; the frame check sequence has already been removed. The block holds the first six bytes (the destination address) aside and decides whether to keep the frame. It keeps frames that match the station address, all-ones broadcast frames, group frames whose CRC hash bin is enabled, and every frame when promiscuous mode is on. Kept frames go into a circular buffer of 256-byte pages in local RAM, one byte per cycle, through a plain write port.

Each stored frame starts with four bytes: a status byte, the page where the next frame will begin, and the stored length in two bytes. The payload is padded to the 60-byte minimum and wraps from the ring's end page back to its first page. After the header is written, the current-page pointer moves to the next frame's page and a one-cycle receive event is raised. Frames are refused while the receiver is stopped, when the ring bounds are not valid, or when the space between the current page and the boundary page cannot hold a maximum-size frame.

Top module: `rx_frame_ring_writer`

## Requirements
- R1: While reset is held and right after it, `mem_we` and `rx_ok` are 0, `rx_ready` is 1 and `cur_pg` is 0.
- R2: A destination with bit 0 of its first byte clear is kept only if all six bytes equal `station_addr`. Byte k on the wire is compared with `station_addr[8k+7:8k]`. A frame that fails the filter causes no RAM write, no `rx_ok` and no change to `cur_pg`.
- R3: When promiscuous mode is off, a destination of six 0xFF bytes is kept only when `cfg_bcast_en` is 1.
- R4: When promiscuous mode is off, any other destination with bit 0 of byte 0 set is kept only when `cfg_mcast_en` is 1 and `mcast_hash[h]` is 1. Here h is bits 31:26 of a CRC register that starts at all ones and is shifted left once per destination bit. Bits are fed least significant first, starting with byte 0. When bit 31 XOR the data bit is 1, the shifted register is XORed with 0x04C11DB7. No final inversion is applied.
- R5: With `cfg_promisc` set, every frame passes the filter, whatever its destination.
- R6: The header occupies bytes `cur_pg*256 + 0..3` and holds, in order: status, next page, length low, length high. Status is 0x01, ORed with 0x20 when bit 0 of destination byte 0 is set. Length is the padded payload count plus 4.
- R7: Payload byte i is written at `cur_pg*256 + 4 + i`, in arrival order. When the address reaches `ring_stop_pg*256`, it continues from `ring_start_pg*256`. The payload is written before the header.
- R8: A kept frame with fewer than 60 bytes is extended with zero bytes to 60.
- R9: The next page is `cur_pg + floor((length + 4 + 255) / 256)`. If that is at or above `ring_stop_pg`, `ring_stop_pg - ring_start_pg` is subtracted.
- R10: A frame is refused at its first byte when `ring_stop_pg <= ring_start_pg`, or when the free space is below 1518 bytes. Free space is `(boundary_pg - cur_pg)*256` when `cur_pg < boundary_pg`; otherwise it is `((ring_stop_pg - ring_start_pg) - (cur_pg - boundary_pg))*256`.
- R11: While `rx_stopped` is 1 at a frame's first byte, the whole frame is refused.
- R12: A frame that ends before its sixth byte is dropped without writes. For a kept frame, `rx_ok` is high for exactly one cycle, the cycle after the last header byte is written, and `cur_pg` takes the next-page value in that same cycle.
- R13: After the sixth byte of a frame that is at least seven bytes long, `rx_ready` is low for exactly 7 cycles: one decision cycle plus six cycles to write the held destination bytes. It is also low while padding and header bytes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Stream byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Stream byte |
| rx_ready | output | 1 | Block takes the byte this cycle |
| rx_stopped | input | 1 | Receiver stopped; frames refused |
| cfg_promisc | input | 1 | Keep every frame |
| cfg_bcast_en | input | 1 | Keep broadcast frames |
| cfg_mcast_en | input | 1 | Keep hashed group frames |
| station_addr | input | 48 | Station address, wire byte k at bits 8k+7:8k |
| mcast_hash | input | 64 | Group hash bins |
| ring_start_pg | input | PAGE_W | First page of the ring |
| ring_stop_pg | input | PAGE_W | Page just past the ring |
| boundary_pg | input | PAGE_W | Oldest page still owned by software |
| cur_pg_load | input | 1 | Load `cur_pg_wdata` while idle |
| cur_pg_wdata | input | PAGE_W | Value to load into the current page |
| cur_pg | output | PAGE_W | Page where the next frame goes |
| mem_we | output | 1 | RAM byte write strobe |
| mem_addr | output | PAGE_W+8 | RAM byte address |
| mem_wdata | output | 8 | RAM byte data |
| rx_ok | output | 1 | One-cycle pulse per stored frame |

## Verification
The RAM write outputs are combinational from state, so a write shows in the same cycle that its byte is accepted or its padding or header step runs. Payload bytes come first, padding follows in consecutive cycles, and the four header bytes come after that. `rx_ok` and the new `cur_pg` appear one cycle after the last header byte. Stimulus changes at the falling edge, and the outputs are sampled 1 ns later, well before the next rising edge. This means each write is seen exactly once, in the cycle in which it commits. A scoreboard holds the expected writes in order, and each `rx_ok` must arrive only once that queue is empty. The `rx_ready` stall is counted on the same samples, so the seven-cycle decision-and-flush gap is measured in cycles.

// File: rtl/rxf_pkg.sv
// Shared types and constants for the receive filter and ring writer.
// Assumes byte-wide RAM writes and 256-byte ring pages.
package rxf_pkg;

    localparam int DEST_BYTES = 6;
    localparam int MIN_FRAME  = 60;
    localparam int MAX_FRAME  = 1514;
    localparam int HDR_BYTES  = 4;
    localparam int FCS_BYTES  = 4;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [7:0]  STS_OK    = 8'h01;
    localparam logic [7:0]  STS_GROUP = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEST, ST_DECIDE, ST_FLUSH,
        ST_BODY, ST_PAD, ST_HDR, ST_DROP
    } rxf_state_e;

    // One byte of the destination hash CRC, data taken least significant bit first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_addr_filter.sv
// Holds the six destination bytes of a frame, hashes them as they arrive,
// and gives the keep/drop verdict once all six are in.
// Assumes the caller loads at most six bytes per frame and marks the first.
module rxf_addr_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic        first_i,
    input  logic [7:0]  data_i,
    input  logic        promisc_i,
    input  logic        bcast_en_i,
    input  logic        mcast_en_i,
    input  logic [47:0] station_i,
    input  logic [63:0] hash_i,
    output logic [47:0] dest_o,
    output logic        accept_o,
    output logic        group_o
);

    logic [7:0]  dest_q [DEST_BYTES];
    logic [2:0]  cnt_q;
    logic [2:0]  slot;
    logic [31:0] crc_q;
    logic        is_bcast;
    logic        is_mine;

    assign slot = first_i ? 3'd0 : cnt_q;

    generate
        for (genvar b = 0; b < DEST_BYTES; b++) begin : g_byte
            // Capture destination byte b when its slot comes up.
            always_ff @(posedge clk) begin
                if (!rst_n)                            dest_q[b] <= '0;
                else if (load_i && slot == 3'(b))      dest_q[b] <= data_i;
            end
            assign dest_o[8*b +: 8] = dest_q[b];
        end
    endgenerate

    // Byte count and running hash CRC, restarted by the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            crc_q <= '1;
        end else if (load_i) begin
            cnt_q <= slot + 3'd1;
            crc_q <= crc32_byte(first_i ? 32'hFFFF_FFFF : crc_q, data_i);
        end
    end

    // Verdict from the held destination and the configuration.
    always_comb begin
        is_bcast = (dest_o == 48'hFFFF_FFFF_FFFF);
        is_mine  = (dest_o == station_i);
        group_o  = dest_q[0][0];
        if (promisc_i)     accept_o = 1'b1;
        else if (is_bcast) accept_o = bcast_en_i;
        else if (group_o)  accept_o = mcast_en_i && hash_i[crc_q[31:26]];
        else               accept_o = is_mine;
    end

    a_r2_dest_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 3'(DEST_BYTES));

endmodule

// File: rtl/rxf_ring_calc.sv
// Ring arithmetic in pages: whether a maximum frame still fits before the
// boundary, and where the frame after this one will start.
// Assumes the current page lies inside the ring and LEN_W > PAGE_W.
module rxf_ring_calc
    import rxf_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [PAGE_W-1:0] cur_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] stop_i,
    input  logic [PAGE_W-1:0] bnd_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              room_ok_o,
    output logic [PAGE_W-1:0] next_pg_o
);

    localparam int FREE_W = PAGE_W + 9;
    localparam logic [FREE_W-1:0] NEED_BYTES = FREE_W'(MAX_FRAME + HDR_BYTES);
    localparam logic [LEN_W:0]    SPAN_ADD   = (LEN_W+1)'(HDR_BYTES + FCS_BYTES + 255);

    logic [PAGE_W:0]   size_pg;
    logic [PAGE_W:0]   used_pg;
    logic [PAGE_W:0]   free_pg;
    logic [LEN_W:0]    span_sum;
    logic [LEN_W-1:0]  nxt_w;

    // Free pages between the write point and the boundary.
    always_comb begin
        size_pg = {1'b0, stop_i} - {1'b0, start_i};
        used_pg = {1'b0, cur_i} - {1'b0, bnd_i};
        if (cur_i < bnd_i)         free_pg = {1'b0, bnd_i} - {1'b0, cur_i};
        else if (used_pg < size_pg) free_pg = size_pg - used_pg;
        else                        free_pg = '0;
        room_ok_o = (stop_i > start_i) && ({free_pg, 8'h00} >= NEED_BYTES);
    end

    // Page of the next frame, folded back into the ring.
    always_comb begin
        span_sum = {1'b0, len_i} + SPAN_ADD;
        nxt_w    = LEN_W'(cur_i) + LEN_W'(span_sum[LEN_W:8]);
        if (nxt_w >= LEN_W'(stop_i)) nxt_w = nxt_w - LEN_W'(size_pg);
        next_pg_o = nxt_w[PAGE_W-1:0];
    end

endmodule

// File: rtl/rx_frame_ring_writer.sv
// Receive path: filters each incoming frame on its destination and writes
// kept frames, behind a four-byte header, into a paged RAM ring.
// Assumes the ring configuration is stable while a frame is in flight.
module rx_frame_ring_writer
    import rxf_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              rx_stopped,
    input  logic              cfg_promisc,
    input  logic              cfg_bcast_en,
    input  logic              cfg_mcast_en,
    input  logic [47:0]       station_addr,
    input  logic [63:0]       mcast_hash,
    input  logic [PAGE_W-1:0] ring_start_pg,
    input  logic [PAGE_W-1:0] ring_stop_pg,
    input  logic [PAGE_W-1:0] boundary_pg,
    input  logic              cur_pg_load,
    input  logic [PAGE_W-1:0] cur_pg_wdata,
    output logic [PAGE_W-1:0] cur_pg,
    output logic              mem_we,
    output logic [PAGE_W+7:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rx_ok
);

    localparam int ADDR_W = PAGE_W + 8;
    localparam logic [2:0] LAST_DEST = 3'(DEST_BYTES - 1);

    rxf_state_e         st_q;
    logic [ADDR_W-1:0]  wptr_q;
    logic [LEN_W-1:0]   len_q;
    logic [2:0]         k_q;
    logic               eof_q;
    logic               ok_q;
    logic [PAGE_W-1:0]  cur_q;

    logic               take;
    logic               f_load;
    logic               f_accept;
    logic               f_group;
    logic [47:0]        f_dest;
    logic               room_ok;
    logic [PAGE_W-1:0]  next_pg;
    logic [LEN_W-1:0]   total_len;
    logic               pad_need;
    logic [7:0]         status;

    assign rx_ready  = (st_q == ST_IDLE) || (st_q == ST_DEST) ||
                       (st_q == ST_BODY) || (st_q == ST_DROP);
    assign take      = rx_valid && rx_ready;
    assign f_load    = take && (((st_q == ST_IDLE) && rx_sof && !rx_stopped && room_ok) ||
                                (st_q == ST_DEST));
    assign total_len = len_q + LEN_W'(HDR_BYTES);
    assign pad_need  = (len_q < LEN_W'(MIN_FRAME));
    assign status    = STS_OK | (f_group ? STS_GROUP : 8'h00);
    assign cur_pg    = cur_q;
    assign rx_ok     = ok_q;

    rxf_addr_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (f_load),
        .first_i    (st_q == ST_IDLE),
        .data_i     (rx_data),
        .promisc_i  (cfg_promisc),
        .bcast_en_i (cfg_bcast_en),
        .mcast_en_i (cfg_mcast_en),
        .station_i  (station_addr),
        .hash_i     (mcast_hash),
        .dest_o     (f_dest),
        .accept_o   (f_accept),
        .group_o    (f_group)
    );

    rxf_ring_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_calc (
        .cur_i     (cur_q),
        .start_i   (ring_start_pg),
        .stop_i    (ring_stop_pg),
        .bnd_i     (boundary_pg),
        .len_i     (len_q),
        .room_ok_o (room_ok),
        .next_pg_o (next_pg)
    );

    // Step the write address, folding the ring end back to its start.
    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
        logic [ADDR_W-1:0] n;
        n = p + 1'b1;
        if (n == {ring_stop_pg, 8'h00}) n = {ring_start_pg, 8'h00};
        return n;
    endfunction

    // RAM write port driven straight from the sequencing state.
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = wptr_q;
        mem_wdata = 8'h00;
        case (st_q)
            ST_FLUSH: begin
                mem_we    = 1'b1;
                mem_wdata = f_dest[{k_q, 3'b000} +: 8];
            end
            ST_BODY: begin
                mem_we    = rx_valid;
                mem_wdata = rx_data;
            end
            ST_PAD:  mem_we = pad_need;
            ST_HDR: begin
                mem_we   = 1'b1;
                mem_addr = {cur_q, 6'b0, k_q[1:0]};
                case (k_q[1:0])
                    2'd0:    mem_wdata = status;
                    2'd1:    mem_wdata = 8'(next_pg);
                    2'd2:    mem_wdata = total_len[7:0];
                    default: mem_wdata = total_len[15:8];
                endcase
            end
            default: ;
        endcase
    end

    // Frame sequencing: capture, decide, flush, stream, pad, header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wptr_q <= '0;
            len_q  <= '0;
            k_q    <= '0;
            eof_q  <= 1'b0;
            ok_q   <= 1'b0;
            cur_q  <= '0;
        end else begin
            ok_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cur_pg_load) cur_q <= cur_pg_wdata;
                    if (take && rx_sof) begin
                        if (f_load) begin
                            k_q  <= 3'd1;
                            st_q <= rx_eof ? ST_IDLE : ST_DEST;
                        end else if (!rx_eof) begin
                            st_q <= ST_DROP;
                        end
                    end
                end
                ST_DEST: if (take) begin
                    k_q <= k_q + 3'd1;
                    if (k_q == LAST_DEST) begin
                        eof_q <= rx_eof;
                        st_q  <= ST_DECIDE;
                    end else if (rx_eof) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_DECIDE: begin
                    if (f_accept) begin
                        st_q   <= ST_FLUSH;
                        k_q    <= '0;
                        wptr_q <= {cur_q, 8'(HDR_BYTES)};
                        len_q  <= LEN_W'(DEST_BYTES);
                    end else begin
                        st_q <= eof_q ? ST_IDLE : ST_DROP;
                    end
                end
                ST_FLUSH: begin
                    wptr_q <= step_ptr(wptr_q);
                    k_q    <= k_q + 3'd1;
                    if (k_q == LAST_DEST) st_q <= eof_q ? ST_PAD : ST_BODY;
                end
                ST_BODY: if (take) begin
                    wptr_q <= step_ptr(wptr_q);
                    len_q  <= len_q + 1'b1;
                    if (rx_eof) st_q <= ST_PAD;
                end
                ST_PAD: begin
                    if (pad_need) begin
                        wptr_q <= step_ptr(wptr_q);
                        len_q  <= len_q + 1'b1;
                    end else begin
                        st_q <= ST_HDR;
                        k_q  <= '0;
                    end
                end
                ST_HDR: begin
                    k_q <= k_q + 3'd1;
                    if (k_q == 3'd3) begin
                        cur_q <= next_pg;
                        ok_q  <= 1'b1;
                        st_q  <= ST_IDLE;
                    end
                end
                default: if (take && rx_eof) st_q <= ST_IDLE;
            endcase
        end
    end

    a_r12_ok_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);
    a_r12_ok_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ok) |-> $past(st_q == ST_HDR));
    a_r9_next_page_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> (cur_pg >= ring_start_pg) && (cur_pg < ring_stop_pg));
    a_r10_full_ring_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && take && rx_sof && !room_ok) |=> (st_q != ST_DEST));
    a_r11_stopped_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && take && rx_sof && rx_stopped) |=> (st_q != ST_DEST));
    a_r13_no_take_during_header: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_addr[7:0] < 8'(HDR_BYTES)) && !rx_valid) |-> (rx_ready == 1'b0) || (st_q == ST_BODY));

endmodule

// File: tb/tb_rx_frame_ring_writer.sv
module tb_rx_frame_ring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        rx_stopped = 0, cfg_promisc = 0, cfg_bcast_en = 0, cfg_mcast_en = 0;
    logic [47:0] station_addr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
    logic [63:0] mcast_hash = '0;
    logic [7:0]  ring_start_pg = 8'h40, ring_stop_pg = 8'h60, boundary_pg = 8'h40;
    logic        cur_pg_load = 0;
    logic [7:0]  cur_pg_wdata = '0;
    logic [7:0]  cur_pg;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        rx_ok;

    always #2 clk = ~clk;

    rx_frame_ring_writer dut (.*);

    int n_tests = 0, n_fail = 0, ok_cnt = 0, ok_exp = 0, stall = 0, m_cur = 0;
    bit done = 0;
    string cur_req = "R1";
    logic [23:0] exp_q [$];
    logic [7:0]  fr [$];

    task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected writes in order and checks the event timing.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && !done) begin
                if (rx_valid && !rx_ready) stall++;
                if (mem_we) begin
                    if (exp_q.size() == 0)
                        chk(0, cur_req, "unexpected RAM write at", int'(mem_addr), 0);
                    else begin
                        logic [23:0] e;
                        e = exp_q.pop_front();
                        chk(mem_addr == e[23:8] && mem_wdata == e[7:0], cur_req, "RAM write addr/data",
                            int'({mem_addr, mem_wdata}), int'(e));
                    end
                end
                if (rx_ok) begin
                    ok_cnt++;
                    chk(exp_q.size() == 0, "R12", "writes left at rx_ok", exp_q.size(), 0);
                end
            end
        end
    end

    // Bench-side hash index of the destination held in fr[0..5].
    function automatic int mc_index();
        logic [31:0] r;
        bit top, bin;
        r = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            bin = fr[n / 8][n % 8];
            top = r[31];
            r = r << 1;
            if (top ^ bin) r = r ^ 32'h04C1_1DB7;
        end
        return int'(r[31:26]);
    endfunction

    task automatic mk_frame(input logic [47:0] d, input int len, input int seed);
        fr.delete();
        for (int i = 0; i < len; i++)
            fr.push_back(i < 6 ? d[8*i +: 8] : 8'(i * 3 + seed));
    endtask

    // Scoreboard driver: predict the writes, then play the frame and settle.
    task automatic run_frame(input string req);
        int size, start, stop, idx, bnd, avail, plen, total, nxt, a;
        bit keep, bc, grp, mine;
        size  = fr.size();
        start = int'(ring_start_pg) * 256;
        stop  = int'(ring_stop_pg) * 256;
        idx   = m_cur * 256;
        bnd   = int'(boundary_pg) * 256;
        if (stop <= start) avail = 0;
        else if (idx < bnd) avail = bnd - idx;
        else avail = (stop - start) - (idx - bnd);
        keep = (size >= 6) && !rx_stopped && (stop > start) && (avail >= 1518);
        if (keep) begin
            bc = 1; mine = 1;
            for (int i = 0; i < 6; i++) begin
                if (fr[i] != 8'hFF) bc = 0;
                if (fr[i] != station_addr[8*i +: 8]) mine = 0;
            end
            grp = fr[0][0];
            if (cfg_promisc) keep = 1;
            else if (bc) keep = cfg_bcast_en;
            else if (grp) keep = cfg_mcast_en && mcast_hash[mc_index()];
            else keep = mine;
        end
        if (keep) begin
            plen  = (size < 60) ? 60 : size;
            total = plen + 4;
            nxt   = idx + ((total + 4 + 255) / 256) * 256;
            if (nxt >= stop) nxt -= (stop - start);
            a = idx + 4;
            for (int i = 0; i < plen; i++) begin
                exp_q.push_back({16'(a), (i < size) ? fr[i] : 8'h00});
                a++;
                if (a == stop) a = start;
            end
            exp_q.push_back({16'(idx),     8'h01 | (fr[0][0] ? 8'h20 : 8'h00)});
            exp_q.push_back({16'(idx + 1), 8'(nxt / 256)});
            exp_q.push_back({16'(idx + 2), 8'(total)});
            exp_q.push_back({16'(idx + 3), 8'(total / 256)});
            m_cur = nxt / 256;
            ok_exp++;
        end
        cur_req = req;
        stall = 0;
        for (int i = 0; i < size; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == size - 1); rx_data = fr[i];
            #1;
            while (!rx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0, req, "writes still pending", exp_q.size(), 0);
        chk(int'(cur_pg) == m_cur, req, "cur_pg after frame", int'(cur_pg), m_cur);
        chk(ok_cnt == ok_exp, req, "rx_ok count", ok_cnt, ok_exp);
    endtask

    task automatic load_cur(input logic [7:0] v);
        cur_pg_load = 1; cur_pg_wdata = v;
        @(negedge clk);
        cur_pg_load = 0;
        m_cur = int'(v);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_we == 0 && rx_ok == 0, "R1", "write/event in reset", int'({mem_we, rx_ok}), 0);
        chk(rx_ready == 1 && cur_pg == 0, "R1", "ready/cur_pg in reset", int'({rx_ready, cur_pg}), 9'h100);
        rst_n = 1;
        @(negedge clk); #1;
        chk(mem_we == 0 && rx_ok == 0 && cur_pg == 0, "R1", "state after reset", int'({mem_we, rx_ok, cur_pg}), 0);
        @(negedge clk);
        load_cur(8'h40);

        // R2 / R6 / R7: station match, 64 bytes; R13 stall count.
        mk_frame(station_addr, 64, 1);
        run_frame("R2_R6_R7");
        chk(stall == 7, "R13", "rx_ready low cycles after dest", stall, 7);
        // R2: mismatch is silent.
        mk_frame(48'h99_88_77_66_55_04, 64, 2);
        run_frame("R2");
        // R8: short frame padded.
        mk_frame(station_addr, 20, 3);
        run_frame("R8");
        // R3: broadcast off then on.
        mk_frame(48'hFFFF_FFFF_FFFF, 70, 4);
        run_frame("R3");
        cfg_bcast_en = 1;
        run_frame("R3");
        // R4: group frame, hash bin clear, set, then group disable.
        cfg_mcast_en = 1;
        mk_frame(48'h01_00_00_5E_00_01, 80, 5);
        run_frame("R4");
        h = mc_index();
        mcast_hash[h] = 1'b1;
        run_frame("R4");
        cfg_mcast_en = 0;
        run_frame("R4");
        // R5: promiscuous keeps a foreign unicast.
        cfg_promisc = 1;
        mk_frame(48'h99_88_77_66_55_04, 100, 6);
        run_frame("R5");
        cfg_promisc = 0;
        // R7 / R9: wrap across the ring end.
        ring_stop_pg = 8'h50; boundary_pg = 8'h4E;
        load_cur(8'h4F);
        mk_frame(station_addr, 300, 7);
        run_frame("R7_R9");
        chk(int'(cur_pg) == 8'h41, "R9", "next page wrapped", int'(cur_pg), 8'h41);
        // R10: exactly 6 free pages fits, then 5 do not.
        boundary_pg = 8'h47;
        mk_frame(station_addr, 100, 8);
        run_frame("R10");
        run_frame("R10");
        // R10: empty ring bounds.
        boundary_pg = 8'h40;
        ring_stop_pg = 8'h40;
        run_frame("R10");
        ring_stop_pg = 8'h50;
        // R11: stopped receiver.
        rx_stopped = 1;
        run_frame("R11");
        rx_stopped = 0;
        // R12: frame shorter than a destination.
        mk_frame(station_addr, 4, 9);
        run_frame("R12");
        // R6 with group status on a kept broadcast after everything else.
        mk_frame(48'hFFFF_FFFF_FFFF, 61, 10);
        run_frame("R6");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule